// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the purely combinational arithmetic and logic unit of a small register-based microcontroller core. Each cycle it receives an operation code, a destination operand `a_i`, a source operand `b_i` (register or immediate, the choice is made upstream), the current carry flag and the current zero flag. It returns the 8-bit result, the next value of six status flags, and a per-flag write-enable mask. The surrounding core writes only the flags whose mask bit is set and keeps the rest.

All add, subtract, negate, increment and decrement work goes through one shared adder. Logic, complement, shift, rotate and nibble-swap work goes through a separate bit-manipulation unit. Compare operations use the subtract codes; the core simply does not write the result back. The zero flag for subtract-with-carry chains across bytes, so multi-byte compares and subtractions give a correct overall zero.

Top module: `alu8_core`

## Requirements
- R1: `op_i` selects the operation with these codes: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 AND, 5 OR, 6 XOR, 7 one's complement, 8 negate, 9 increment, 10 decrement, 11 shift left, 12 logical shift right, 13 rotate left through carry, 14 rotate right through carry, 15 arithmetic shift right, 16 nibble swap; add and add-with-carry give `a_i + b_i (+ carry_i)`, write all six flags, C is the carry out of bit 7, H the carry out of bit 3 and V the signed overflow.
- R2: Flag vectors use bit 0 = C, 1 = Z, 2 = N, 3 = V, 4 = S, 5 = H in both `flags_o` and `flag_we_o`; subtract and subtract-with-carry give `a_i - b_i (- carry_i)`, write all six flags, C is the borrow out of bit 7, H the borrow into bit 4 and V the signed overflow.
- R3: For subtract-with-carry, Z is set only when the result is zero and `zero_i` is 1; for every other operation that writes Z, Z is 1 exactly when the result is zero.
- R4: AND, OR and XOR write only Z, N, V and S, with V forced to 0; C and H are not written.
- R5: Increment and decrement write only Z, N, V and S; V is set when increment yields 0x80 or decrement yields 0x7F; C is never written.
- R6: One's complement gives 0xFF minus `a_i`, sets C to 1, clears V and writes C, Z, N, V and S; negate gives 0 minus `a_i`, writes all six flags, C set when the result is nonzero, V set when the result is 0x80, H the borrow into bit 4.
- R7: Shift left moves bit 7 into C and writes 0 into bit 0; rotate left puts `carry_i` into bit 0 and bit 7 into C; both write all six flags with H equal to input bit 3.
- R8: Logical shift right puts 0 in bit 7, rotate right puts `carry_i` in bit 7, arithmetic shift right keeps bit 7; all three move bit 0 into C and write C, Z, N, V and S.
- R9: Nibble swap exchanges bits 7..4 with bits 3..0 and its write mask is all zero.
- R10: Whenever N and S are written, N equals result bit 7 and S equals N XOR V; for shifts and rotates V equals N XOR C of the new values.
- R11: For one's complement, negate, increment, decrement, the shifts, rotates and swap, `b_i` has no effect on the result, the write mask or any written flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code (see R1) |
| a_i | input | 8 | Destination operand |
| b_i | input | 8 | Source operand or immediate |
| carry_i | input | 1 | Current carry flag |
| zero_i | input | 1 | Current zero flag, used for subtract-with-carry chaining |
| result_o | output | 8 | Operation result |
| flags_o | output | 6 | Next flag values, C Z N V S H from bit 0 up |
| flag_we_o | output | 6 | Write enable per flag, same bit order |

## Verification
Every result and flag of this block is due in the same cycle as its inputs, since no register lies between ports. The bench drives a new operation at a falling clock edge and records the expected result, flags and mask in a queue; the monitor pops that entry at the very next rising edge, after the logic has settled and before the next operation is driven, so each comparison sees exactly the stimulus it belongs to. Flag values are compared only under the expected write mask, and the mask itself is compared in full.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_COM  = 5'd7,
        OP_NEG  = 5'd8,
        OP_INC  = 5'd9,
        OP_DEC  = 5'd10,
        OP_LSL  = 5'd11,
        OP_LSR  = 5'd12,
        OP_ROL  = 5'd13,
        OP_ROR  = 5'd14,
        OP_ASR  = 5'd15,
        OP_SWAP = 5'd16
    } alu_op_e;

    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;
    localparam int FL_COUNT = 6;

    typedef logic [FL_COUNT-1:0] flag_vec_t;

    localparam flag_vec_t MASK_ALL  = 6'b111111;
    localparam flag_vec_t MASK_ZNVS = 6'b011110;
    localparam flag_vec_t MASK_CZNVS = 6'b011111;

    function automatic flag_vec_t flag_mask(alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC,
            OP_NEG, OP_LSL, OP_ROL:            return MASK_ALL;
            OP_AND, OP_OR, OP_XOR,
            OP_INC, OP_DEC:                    return MASK_ZNVS;
            OP_COM, OP_LSR, OP_ROR, OP_ASR:    return MASK_CZNVS;
            default:                           return '0;
        endcase
    endfunction

    function automatic logic uses_adder(alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC,
            OP_NEG, OP_INC, OP_DEC:            return 1'b1;
            default:                           return 1'b0;
        endcase
    endfunction

    function automatic logic is_logic(alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             sub_i,
    input  logic             cb_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             c_o,
    output logic             h_o,
    output logic             v_o
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] y_eff;
    logic             cin_eff;
    logic [WIDTH:0]   full;
    logic [HALF:0]    low;

    always_comb begin
        y_eff   = sub_i ? ~y_i : y_i;
        cin_eff = sub_i ? ~cb_i : cb_i;
        full    = {1'b0, x_i} + {1'b0, y_eff} + {{WIDTH{1'b0}}, cin_eff};
        low     = {1'b0, x_i[HALF-1:0]} + {1'b0, y_eff[HALF-1:0]} + {{HALF{1'b0}}, cin_eff};
        sum_o   = full[WIDTH-1:0];
        c_o     = sub_i ? ~full[WIDTH] : full[WIDTH];
        h_o     = sub_i ? ~low[HALF] : low[HALF];
        v_o     = (x_i[WIDTH-1] == y_eff[WIDTH-1]) && (sum_o[WIDTH-1] != x_i[WIDTH-1]);
    end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] res_o,
    output logic             c_o,
    output logic             h_o,
    output logic             v_o
);
    localparam int HALF = WIDTH / 2;
    localparam int MSB  = WIDTH - 1;

    logic shift_op;

    always_comb begin
        res_o = a_i;
        c_o   = 1'b0;
        case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_COM:  begin res_o = ~a_i; c_o = 1'b1; end
            OP_LSL:  begin res_o = {a_i[MSB-1:0], 1'b0};    c_o = a_i[MSB]; end
            OP_ROL:  begin res_o = {a_i[MSB-1:0], carry_i}; c_o = a_i[MSB]; end
            OP_LSR:  begin res_o = {1'b0, a_i[MSB:1]};      c_o = a_i[0]; end
            OP_ROR:  begin res_o = {carry_i, a_i[MSB:1]};   c_o = a_i[0]; end
            OP_ASR:  begin res_o = {a_i[MSB], a_i[MSB:1]};  c_o = a_i[0]; end
            OP_SWAP: res_o = {a_i[HALF-1:0], a_i[MSB:HALF]};
            default: res_o = a_i;
        endcase
        shift_op = (op_i == OP_LSL) || (op_i == OP_ROL) || (op_i == OP_LSR)
                || (op_i == OP_ROR) || (op_i == OP_ASR);
        v_o = shift_op ? (res_o[MSB] ^ c_o) : 1'b0;
        h_o = a_i[HALF-1];
    end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] res_i,
    input  logic             zero_i,
    input  logic             c_i,
    input  logic             h_i,
    input  logic             v_i,
    output flag_vec_t        flags_o,
    output flag_vec_t        we_o
);
    logic res_zero;

    always_comb begin
        res_zero       = (res_i == '0);
        flags_o        = '0;
        flags_o[FL_C]  = c_i;
        flags_o[FL_Z]  = (op_i == OP_SBC) ? (res_zero & zero_i) : res_zero;
        flags_o[FL_N]  = res_i[WIDTH-1];
        flags_o[FL_V]  = v_i;
        flags_o[FL_S]  = res_i[WIDTH-1] ^ v_i;
        flags_o[FL_H]  = h_i;
        we_o           = flag_mask(op_i);
    end

    // R3: a chained subtract may never raise Z when the incoming zero is clear
    always_comb begin
        if (op_i == OP_SBC && !zero_i)
            p_chain_zero_r3: assert (!flags_o[FL_Z]) else $error("p_chain_zero_r3");
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [4:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             carry_i,
    input  logic             zero_i,
    output logic [WIDTH-1:0] result_o,
    output logic [5:0]       flags_o,
    output logic [5:0]       flag_we_o
);
    localparam int HALF = WIDTH / 2;
    localparam int MSB  = WIDTH - 1;
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    alu_op_e op;
    assign op = alu_op_e'(op_i);

    logic [WIDTH-1:0] add_x, add_y, add_sum, bit_res, res_sel;
    logic             add_sub, add_cb, add_c, add_h, add_v;
    logic             bit_c, bit_h, bit_v;
    logic             c_sel, h_sel, v_sel;
    flag_vec_t        fl, we;

    always_comb begin
        add_x   = a_i;
        add_y   = b_i;
        add_sub = 1'b0;
        add_cb  = 1'b0;
        case (op)
            OP_ADC: add_cb = carry_i;
            OP_SUB: add_sub = 1'b1;
            OP_SBC: begin add_sub = 1'b1; add_cb = carry_i; end
            OP_NEG: begin add_x = '0; add_y = a_i; add_sub = 1'b1; end
            OP_INC: add_y = ONE;
            OP_DEC: begin add_y = ONE; add_sub = 1'b1; end
            default: ;
        endcase
    end

    alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
        .x_i   (add_x),
        .y_i   (add_y),
        .sub_i (add_sub),
        .cb_i  (add_cb),
        .sum_o (add_sum),
        .c_o   (add_c),
        .h_o   (add_h),
        .v_o   (add_v)
    );

    alu8_bitops #(.WIDTH(WIDTH)) u_bitops (
        .op_i    (op),
        .a_i     (a_i),
        .b_i     (b_i),
        .carry_i (carry_i),
        .res_o   (bit_res),
        .c_o     (bit_c),
        .h_o     (bit_h),
        .v_o     (bit_v)
    );

    always_comb begin
        if (uses_adder(op)) begin
            res_sel = add_sum;
            c_sel   = add_c;
            h_sel   = add_h;
            v_sel   = add_v;
        end else begin
            res_sel = bit_res;
            c_sel   = bit_c;
            h_sel   = bit_h;
            v_sel   = bit_v;
        end
    end

    alu8_flags #(.WIDTH(WIDTH)) u_flags (
        .op_i    (op),
        .res_i   (res_sel),
        .zero_i  (zero_i),
        .c_i     (c_sel),
        .h_i     (h_sel),
        .v_i     (v_sel),
        .flags_o (fl),
        .we_o    (we)
    );

    assign result_o  = res_sel;
    assign flags_o   = fl;
    assign flag_we_o = we;

    always_comb begin
        if (is_logic(op)) begin
            p_logic_keep_ch_r4: assert (!flag_we_o[FL_C] && !flag_we_o[FL_H])
                else $error("p_logic_keep_ch_r4");
            p_logic_sign_r10: assert (!flags_o[FL_V] && flags_o[FL_S] == result_o[MSB])
                else $error("p_logic_sign_r10");
        end
        if (op == OP_INC || op == OP_DEC)
            p_incdec_keep_c_r5: assert (!flag_we_o[FL_C]) else $error("p_incdec_keep_c_r5");
        if (op == OP_SWAP)
            p_swap_quiet_r9: assert (flag_we_o == '0 && result_o == {a_i[HALF-1:0], a_i[MSB:HALF]})
                else $error("p_swap_quiet_r9");
        if (op == OP_LSL)
            p_lsl_carry_r7: assert (flags_o[FL_C] == a_i[MSB] && !result_o[0])
                else $error("p_lsl_carry_r7");
    end
endmodule

// File: tb/alu8_core_test.sv
module alu8_core_test;

    typedef struct packed {
        logic [7:0] res;
        logic [5:0] fl;
        logic [5:0] we;
    } expect_t;

    typedef struct {
        expect_t exp;
        string   tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] op_i = '0;
    logic [7:0] a_i = '0, b_i = '0;
    logic       carry_i = 1'b0, zero_i = 1'b0;
    logic [7:0] result_o;
    logic [5:0] flags_o, flag_we_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    item_t q[$];

    always #2 clk = ~clk;

    alu8_core uut (
        .op_i      (op_i),
        .a_i       (a_i),
        .b_i       (b_i),
        .carry_i   (carry_i),
        .zero_i    (zero_i),
        .result_o  (result_o),
        .flags_o   (flags_o),
        .flag_we_o (flag_we_o)
    );

    // Independent reference built from the requirements
    function automatic expect_t model(logic [4:0] op, logic [7:0] a, logic [7:0] b,
                                      logic ci, logic zi);
        expect_t e;
        logic [8:0] t;
        logic c, h, v;
        logic [7:0] r;
        bit zchain;
        c = 0; h = 0; v = 0; r = 0; zchain = 0; t = 0;
        case (op)
            0, 1: begin
                t = {1'b0, a} + {1'b0, b} + ((op == 1) ? {8'd0, ci} : 9'd0);
                r = t[7:0]; c = t[8];
                h = ({1'b0, a[3:0]} + {1'b0, b[3:0]} + ((op == 1) ? {4'd0, ci} : 5'd0)) > 5'd15;
                v = (a[7] == b[7]) && (r[7] != a[7]);
                e.we = 6'h3F;
            end
            2, 3: begin
                t = {1'b0, a} - {1'b0, b} - ((op == 3) ? {8'd0, ci} : 9'd0);
                r = t[7:0]; c = t[8];
                h = {1'b0, a[3:0]} < ({1'b0, b[3:0]} + ((op == 3) ? {4'd0, ci} : 5'd0));
                v = (a[7] != b[7]) && (r[7] != a[7]);
                zchain = (op == 3);
                e.we = 6'h3F;
            end
            4: begin r = a & b; e.we = 6'h1E; end
            5: begin r = a | b; e.we = 6'h1E; end
            6: begin r = a ^ b; e.we = 6'h1E; end
            7: begin r = 8'hFF - a; c = 1; e.we = 6'h1F; end
            8: begin r = 8'h00 - a; c = (r != 0); v = (r == 8'h80); h = (a[3:0] != 0); e.we = 6'h3F; end
            9: begin r = a + 8'd1; v = (r == 8'h80); e.we = 6'h1E; end
            10: begin r = a - 8'd1; v = (r == 8'h7F); e.we = 6'h1E; end
            11, 13: begin
                r = {a[6:0], (op == 13) ? ci : 1'b0}; c = a[7]; h = a[3];
                v = r[7] ^ c; e.we = 6'h3F;
            end
            12, 14, 15: begin
                r = {(op == 12) ? 1'b0 : (op == 14) ? ci : a[7], a[7:1]}; c = a[0];
                v = r[7] ^ c; e.we = 6'h1F;
            end
            default: begin r = {a[3:0], a[7:4]}; e.we = 6'h00; end
        endcase
        e.res = r;
        e.fl = {h, r[7] ^ v, v, r[7], zchain ? ((r == 0) && zi) : (r == 0), c};
        return e;
    endfunction

    function automatic string tag_of(logic [4:0] op);
        case (op)
            0, 1: return "R1";
            2: return "R2";
            3: return "R3";
            4, 5, 6: return "R4";
            7, 8: return "R6";
            9, 10: return "R5";
            11, 13: return "R7";
            12, 14, 15: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic send(logic [4:0] op, logic [7:0] a, logic [7:0] b,
                        logic ci, logic zi, string tag);
        item_t it;
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; carry_i = ci; zero_i = zi;
        it.exp = model(op, a, b, ci, zi);
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic note(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Monitor: results are combinational, due at the first rising edge after driving
    always @(posedge clk) begin
        if (!rst && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            note(result_o == it.exp.res, it.tag, "result", int'(result_o), int'(it.exp.res));
            note(flag_we_o == it.exp.we, it.tag, "flag mask", int'(flag_we_o), int'(it.exp.we));
            note((flags_o & it.exp.we) == (it.exp.fl & it.exp.we), it.tag, "flags",
                 int'(flags_o & it.exp.we), int'(it.exp.fl & it.exp.we));
            if (it.exp.we[4]) // R10: S = N ^ V, N = result msb
                note(flags_o[4] == (result_o[7] ^ flags_o[3]) && flags_o[2] == result_o[7],
                     "R10", "sign", int'(flags_o), int'(it.exp.fl));
        end
    end

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // Idle state after reset: add of zeros gives zero result, Z set (R1)
        send(0, 8'h00, 8'h00, 0, 0, "R1");
        // R1 add corners
        send(0, 8'h80, 8'h80, 0, 0, "R1");
        send(0, 8'h0F, 8'h01, 0, 0, "R1");
        send(0, 8'h7F, 8'h01, 0, 0, "R1");
        send(1, 8'hFF, 8'h00, 1, 0, "R1");
        send(1, 8'h12, 8'h34, 1, 1, "R1");
        // R2 subtract corners
        send(2, 8'h00, 8'h01, 0, 0, "R2");
        send(2, 8'h80, 8'h01, 0, 0, "R2");
        send(2, 8'h10, 8'h01, 1, 0, "R2");
        send(2, 8'h55, 8'h55, 0, 0, "R2");
        // R3 zero chaining
        send(3, 8'h20, 8'h1F, 1, 1, "R3");
        send(3, 8'h20, 8'h1F, 1, 0, "R3");
        send(3, 8'h00, 8'h00, 1, 1, "R3");
        // R4 logic, carry preserved
        send(4, 8'hF0, 8'h0F, 1, 0, "R4");
        send(5, 8'h80, 8'h01, 1, 0, "R4");
        send(6, 8'hAA, 8'hAA, 0, 0, "R4");
        // R5 inc/dec wrap points
        send(9, 8'h7F, 8'h00, 1, 0, "R5");
        send(9, 8'hFF, 8'h00, 0, 0, "R5");
        send(10, 8'h80, 8'h00, 1, 0, "R5");
        send(10, 8'h01, 8'h00, 0, 0, "R5");
        // R6 complement and negate
        send(7, 8'h00, 8'h00, 0, 0, "R6");
        send(8, 8'h80, 8'h00, 0, 0, "R6");
        send(8, 8'h00, 8'h00, 1, 0, "R6");
        send(8, 8'h01, 8'h00, 0, 0, "R6");
        // R7 left shifts and rotates
        send(11, 8'h88, 8'h00, 1, 0, "R7");
        send(13, 8'h40, 8'h00, 1, 0, "R7");
        // R8 right shifts and rotates
        send(12, 8'h81, 8'h00, 1, 0, "R8");
        send(14, 8'h02, 8'h00, 1, 0, "R8");
        send(15, 8'h81, 8'h00, 0, 0, "R8");
        send(15, 8'h01, 8'h00, 0, 0, "R8");
        // R9 swap
        send(16, 8'hA5, 8'h00, 1, 1, "R9");
        // R11: single-operand ops give the same outputs for two different b values
        for (int op = 7; op <= 16; op++) begin
            send(op[4:0], 8'h93, 8'h00, 1, 1, "R11");
            send(op[4:0], 8'h93, 8'hFF, 1, 1, "R11");
        end
        // Broad sweep over all codes (R1 op encoding)
        for (int i = 0; i < 600; i++) begin
            logic [4:0] op;
            logic [7:0] a, b;
            op = 5'(i % 17);
            a = 8'($urandom);
            b = 8'($urandom);
            send(op, a, b, 1'($urandom), 1'($urandom), tag_of(op));
        end
        @(negedge clk);
        wait (q.size() == 0);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule